// File: doc/BRIEF.md
# ARP Link Initialization Controller

This controller brings a point-to-point datagram link out of soft reset by learning the peer's hardware (MAC) address through ARP. It does this before any payload moves. A falling edge on the soft-reset control bit starts it. The mode input, sampled at that edge, picks one of two behaviours:

- **Client:** the controller asks a transmit framer to send an ARP request, then waits for the matching reply.
- **Server:** the controller waits for the peer's request, then asks the framer to answer it.

A receive parser reports decoded ARP events, the sender address they carry, and whether the sender protocol address matched the configured target.

In client mode a programmable timer watches each outstanding request. When the timer runs out, the controller does three things: it sets a sticky status flag, pulses an interrupt for one clock, and sends the request again. A busy output stays high until the link is up. It is also high while a send command runs.

Top module: `arp_link_init`

## Requirements
- R1: After `rst_n` is released while `soft_rst` is 1, the outputs are: `busy`=1, `link_up`=0, `arp_req_valid`=0, `arp_rep_valid`=0, `irq`=0, `tmo_flag`=0 and `peer_mac`=0.
- R2: Initialization starts only on a 1-to-0 change of `soft_rst`. The detector's previous-value register comes out of `rst_n` at 1. Holding `soft_rst` at 0 or at 1 never starts a second initialization and never raises an emit strobe.
- R3: In client mode, `arp_req_valid` rises on the clock edge that samples the release. It stays high, with no other emit strobe, until a cycle in which `tx_ready` is 1. It is low in the cycle after that handshake.
- R4: In client mode, after the request handshake, a cycle with `rx_valid`=1, `rx_is_reply`=1 and `rx_ip_match`=1 does two things at the next edge: it stores `rx_mac` on `peer_mac` and sets `link_up`=1 with `busy`=0. `peer_mac` does not change while the link is up.
- R5: In client mode, the timer counts from the request handshake. With no accepted reply, after `tmo_limit`+1 clock cycles the controller does three things together: `irq` pulses high for exactly one cycle, `tmo_flag` becomes 1, and `arp_req_valid` is raised again.
- R6: Retries continue until a reply is accepted. `tmo_flag` stays set through a later successful link-up.
- R7: In server mode, the controller waits for a cycle with `rx_valid`=1, `rx_is_request`=1 and `rx_ip_match`=1. That event stores `rx_mac`, and `arp_rep_valid` rises at the next edge and is held until `tx_ready`. `link_up` rises only after that handshake, and `busy` stays 1 until then.
- R8: An event with `rx_ip_match`=0, or of the kind the current mode does not wait for, is ignored. `link_up` stays 0 and `peer_mac` stays 0.
- R9: `server_mode` and `tmo_limit` are captured at the release edge. Changing them afterwards has no effect until the next release.
- R10: `soft_rst`=1 at any time has these effects from the next edge: `link_up`=0, `busy`=1, `peer_mac`=0, `tmo_flag`=0, and both emit strobes low.
- R11: `send_start` while the link is up and idle raises `busy` at the next edge, and `busy` stays high until `send_done`. `send_start` before link-up is ignored.
- R12: Server mode never raises `arp_req_valid` and never pulses `irq`, whatever `tmo_limit` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft-reset control bit; a 1-to-0 change starts initialization |
| server_mode | input | 1 | 0 = client, 1 = server; sampled at release |
| tmo_limit | input | TMO_W | Reply timeout in cycles (expiry after value+1); sampled at release |
| tx_ready | input | 1 | Framer accepts the pending emit request |
| arp_req_valid | output | 1 | Request to emit an ARP request |
| arp_rep_valid | output | 1 | Request to emit an ARP reply |
| rx_valid | input | 1 | Parsed ARP event present this cycle |
| rx_is_reply | input | 1 | Event is an ARP reply |
| rx_is_request | input | 1 | Event is an ARP request |
| rx_ip_match | input | 1 | Event sender protocol address equals the target |
| rx_mac | input | MAC_W | Sender MAC carried by the event |
| send_start | input | 1 | Start a send command |
| send_done | input | 1 | Send command finished |
| busy | output | 1 | High until link-up and while a send runs |
| link_up | output | 1 | Peer address resolved |
| peer_mac | output | MAC_W | Learned peer MAC, zero when not resolved |
| tmo_flag | output | 1 | Sticky reply-timeout status |
| irq | output | 1 | One-cycle pulse on each timeout |

## Verification
The properties take the following for granted about the inputs:

- The parser never flags one event as both a reply and a request.
- `rx_mac` is meaningful only together with `rx_valid`.
- The framer may hold `tx_ready` low for any number of cycles. The emit strobes follow the valid/ready rule: once raised, they do not drop without a handshake unless `soft_rst` is set.
- `send_done` comes only while a send is in progress.

The stimulus drives every input at the falling clock edge. It sets at most one event kind per cycle, pulses `rx_valid` for one cycle, and issues `send_done` only after an accepted `send_start`.

// File: rtl/arp_init_pkg.sv
package arp_init_pkg;
  localparam int MAC_W = 48;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_EMIT,
    ST_REPLY_WAIT,
    ST_REQ_WAIT,
    ST_REPLY_EMIT,
    ST_LINKED
  } init_state_e;
endpackage

// File: rtl/arp_retry_timer.sv
module arp_retry_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/arp_peer_mac_reg.sv
module arp_peer_mac_reg #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (clr) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/arp_init_fsm.sv
module arp_init_fsm
  import arp_init_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic server_mode,
  input  logic tx_ready,
  input  logic rx_valid,
  input  logic rx_is_reply,
  input  logic rx_is_request,
  input  logic rx_ip_match,
  input  logic expire,
  input  logic send_start,
  input  logic send_done,
  output logic init_go,
  output logic req_valid,
  output logic rep_valid,
  output logic timer_restart,
  output logic timer_run,
  output logic mac_load,
  output logic linked,
  output logic busy,
  output logic tmo_flag,
  output logic irq
);
  init_state_e state_q, state_d;
  logic rst_prev_q;
  logic sending_q;
  logic reply_ok, request_ok, retry_evt;

  assign init_go    = rst_prev_q && !soft_rst;
  assign reply_ok   = rx_valid && rx_is_reply && rx_ip_match;
  assign request_ok = rx_valid && rx_is_request && rx_ip_match;

  assign req_valid     = (state_q == ST_REQ_EMIT);
  assign rep_valid     = (state_q == ST_REPLY_EMIT);
  assign linked        = (state_q == ST_LINKED);
  assign timer_restart = req_valid && tx_ready;
  assign timer_run     = (state_q == ST_REPLY_WAIT);
  assign retry_evt     = timer_run && expire && !reply_ok && !soft_rst;
  assign mac_load      = !soft_rst &&
                         ((timer_run && reply_ok) ||
                          ((state_q == ST_REQ_WAIT) && request_ok));
  assign busy          = !linked || sending_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (init_go) state_d = server_mode ? ST_REQ_WAIT : ST_REQ_EMIT;
      ST_REQ_EMIT:   if (tx_ready) state_d = ST_REPLY_WAIT;
      ST_REPLY_WAIT: begin
        if (reply_ok)    state_d = ST_LINKED;
        else if (expire) state_d = ST_REQ_EMIT;
      end
      ST_REQ_WAIT:   if (request_ok) state_d = ST_REPLY_EMIT;
      ST_REPLY_EMIT: if (tx_ready) state_d = ST_LINKED;
      ST_LINKED:     state_d = ST_LINKED;
      default:       state_d = ST_IDLE;
    endcase
    if (soft_rst) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rst_prev_q <= 1'b1;
      sending_q  <= 1'b0;
      tmo_flag   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      state_q    <= state_d;
      rst_prev_q <= soft_rst;
      irq        <= retry_evt;
      if (soft_rst) begin
        sending_q <= 1'b0;
        tmo_flag  <= 1'b0;
      end else begin
        if (retry_evt) tmo_flag <= 1'b1;
        if (linked && send_start && !sending_q) sending_q <= 1'b1;
        else if (send_done)                     sending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/arp_link_init.sv
module arp_link_init
  import arp_init_pkg::*;
#(
  parameter int TMO_W = 32,
  parameter int ADDR_W = MAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              server_mode,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              tx_ready,
  output logic              arp_req_valid,
  output logic              arp_rep_valid,
  input  logic              rx_valid,
  input  logic              rx_is_reply,
  input  logic              rx_is_request,
  input  logic              rx_ip_match,
  input  logic [ADDR_W-1:0] rx_mac,
  input  logic              send_start,
  input  logic              send_done,
  output logic              busy,
  output logic              link_up,
  output logic [ADDR_W-1:0] peer_mac,
  output logic              tmo_flag,
  output logic              irq
);
  logic             init_go, timer_restart, timer_run, expire, mac_load;
  logic [TMO_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       limit_q <= '1;
    else if (init_go) limit_q <= tmo_limit;
  end

  arp_init_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .server_mode   (server_mode),
    .tx_ready      (tx_ready),
    .rx_valid      (rx_valid),
    .rx_is_reply   (rx_is_reply),
    .rx_is_request (rx_is_request),
    .rx_ip_match   (rx_ip_match),
    .expire        (expire),
    .send_start    (send_start),
    .send_done     (send_done),
    .init_go       (init_go),
    .req_valid     (arp_req_valid),
    .rep_valid     (arp_rep_valid),
    .timer_restart (timer_restart),
    .timer_run     (timer_run),
    .mac_load      (mac_load),
    .linked        (link_up),
    .busy          (busy),
    .tmo_flag      (tmo_flag),
    .irq           (irq)
  );

  arp_retry_timer #(.CNT_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (timer_restart),
    .run     (timer_run),
    .limit   (limit_q),
    .expire  (expire)
  );

  arp_peer_mac_reg #(.W(ADDR_W)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst),
    .load  (mac_load),
    .din   (rx_mac),
    .dout  (peer_mac)
  );
endmodule

// File: rtl/arp_link_init_chk.sv
module arp_link_init_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              tx_ready,
  input logic              arp_req_valid,
  input logic              arp_rep_valid,
  input logic              busy,
  input logic              link_up,
  input logic [ADDR_W-1:0] peer_mac,
  input logic              tmo_flag,
  input logic              irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arp_req_valid && !tx_ready && !soft_rst |=> arp_req_valid); // R3
  AST_EMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arp_req_valid && arp_rep_valid)); // R3
  AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arp_rep_valid && !tx_ready && !soft_rst |=> arp_rep_valid); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tmo_flag); // R5
  AST_MAC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    link_up && !soft_rst |=> $stable(peer_mac)); // R4
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!link_up && busy && !tmo_flag && peer_mac == '0)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!arp_req_valid && !arp_rep_valid)); // R2
endmodule

bind arp_link_init arp_link_init_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .tx_ready      (tx_ready),
  .arp_req_valid (arp_req_valid),
  .arp_rep_valid (arp_rep_valid),
  .busy          (busy),
  .link_up       (link_up),
  .peer_mac      (peer_mac),
  .tmo_flag      (tmo_flag),
  .irq           (irq)
);

// File: tb/test_arp_link_init.sv
module test_arp_link_init;
  localparam int TMO_W = 32;
  localparam int MW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b1, server_mode = 1'b0, tx_ready = 1'b0;
  logic [TMO_W-1:0] tmo_limit = 32'd1000;
  logic rx_valid = 1'b0, rx_is_reply = 1'b0, rx_is_request = 1'b0, rx_ip_match = 1'b0;
  logic [MW-1:0] rx_mac = '0;
  logic send_start = 1'b0, send_done = 1'b0;
  logic arp_req_valid, arp_rep_valid, busy, link_up, tmo_flag, irq;
  logic [MW-1:0] peer_mac;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  arp_link_init i_arp_link_init (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .server_mode(server_mode),
    .tmo_limit(tmo_limit), .tx_ready(tx_ready), .arp_req_valid(arp_req_valid),
    .arp_rep_valid(arp_rep_valid), .rx_valid(rx_valid), .rx_is_reply(rx_is_reply),
    .rx_is_request(rx_is_request), .rx_ip_match(rx_ip_match), .rx_mac(rx_mac),
    .send_start(send_start), .send_done(send_done), .busy(busy), .link_up(link_up),
    .peer_mac(peer_mac), .tmo_flag(tmo_flag), .irq(irq)
  );

  // Bits: [4] server, [3] ip match, [2] reply, [1] request, [0] expected link
  localparam logic [4:0] VEC [6] = '{
    5'b01101, 5'b00100, 5'b01010, 5'b11011, 5'b10010, 5'b11100
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_init();
    soft_rst = 1'b1; step(); step();
    soft_rst = 1'b0; step();
  endtask

  task automatic req_handshake();
    tx_ready = 1'b1; step(); tx_ready = 1'b0;
  endtask

  task automatic event_pulse(input logic m, input logic rep, input logic req, input logic [MW-1:0] mac);
    rx_valid = 1'b1; rx_ip_match = m; rx_is_reply = rep; rx_is_request = req; rx_mac = mac;
    step();
    rx_valid = 1'b0; rx_ip_match = 1'b0; rx_is_reply = 1'b0; rx_is_request = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step(); step();
    // R1 reset state
    chk("R1 busy", MW'(busy), 1);
    chk("R1 link_up", MW'(link_up), 0);
    chk("R1 emits", MW'({arp_req_valid, arp_rep_valid}), 0);
    chk("R1 irq/flag", MW'({irq, tmo_flag}), 0);
    chk("R1 peer_mac", peer_mac, 0);
    // R2 held at 1: no emit
    repeat (4) step();
    chk("R2 held high no emit", MW'({arp_req_valid, arp_rep_valid}), 0);

    // Table walk: mode x event kind x match
    for (int i = 0; i < 6; i++) begin
      logic [4:0] v;
      logic [MW-1:0] mac;
      v = VEC[i];
      mac = 48'h0200_0000_1000 + MW'(i);
      server_mode = v[4];
      tmo_limit = 32'd1000;
      release_init();
      if (!v[4]) begin
        chk("R3 req raised", MW'(arp_req_valid), 1);
        req_handshake();
        chk("R3 req dropped", MW'(arp_req_valid), 0);
      end else begin
        chk("R12 no req in server", MW'(arp_req_valid), 0);
      end
      event_pulse(v[3], v[2], v[1], mac);
      if (v[4] && v[0]) begin
        chk("R7 reply raised", MW'(arp_rep_valid), 1);
        chk("R7 busy before reply", MW'(busy), 1);
        chk("R7 link waits", MW'(link_up), 0);
        req_handshake();
      end
      chk(v[0] ? (v[4] ? "R7 link" : "R4 link") : "R8 ignored link", MW'(link_up), MW'(v[0]));
      chk(v[0] ? "R4 mac" : "R8 mac", peer_mac, v[0] ? mac : '0);
      chk("R4 busy", MW'(busy), MW'(!v[0]));
      chk("R8 no reply emit", MW'(arp_rep_valid), 0);
    end

    // Timeout, retry, sampling, send
    server_mode = 1'b0;
    tmo_limit = 32'd3;
    release_init();
    server_mode = 1'b1;          // R9: late change ignored
    tmo_limit = 32'd1000;
    chk("R9 still client", MW'(arp_req_valid), 1);
    req_handshake();
    send_start = 1'b1; step(); send_start = 1'b0;   // R11 ignored before link
    for (int k = 0; k < 2; k++) begin
      step();
      chk("R5 no early irq", MW'(irq), 0);
    end
    step();
    chk("R5 irq pulse", MW'(irq), 1);
    chk("R9 old limit used", MW'(arp_req_valid), 1);
    chk("R5 flag set", MW'(tmo_flag), 1);
    step();
    chk("R5 irq one cycle", MW'(irq), 0);
    chk("R3 req held", MW'(arp_req_valid), 1);
    req_handshake();
    event_pulse(1'b1, 1'b1, 1'b0, 48'h0A0B_0C0D_0E0F);
    chk("R6 linked after retry", MW'(link_up), 1);
    chk("R6 flag kept", MW'(tmo_flag), 1);
    chk("R11 early start ignored", MW'(busy), 0);
    send_start = 1'b1; step(); send_start = 1'b0;
    chk("R11 busy on send", MW'(busy), 1);
    step();
    chk("R11 busy holds", MW'(busy), 1);
    send_done = 1'b1; step(); send_done = 1'b0;
    chk("R11 busy released", MW'(busy), 0);
    repeat (5) step();
    chk("R2 held low no reinit", MW'({arp_req_valid, link_up}), 1);
    soft_rst = 1'b1; step();
    chk("R10 link cleared", MW'(link_up), 0);
    chk("R10 busy", MW'(busy), 1);
    chk("R10 mac cleared", peer_mac, 0);
    chk("R10 flag cleared", MW'(tmo_flag), 0);

    // Server mode with zero limit: no request, no irq
    begin
      int seen;
      seen = 0;
      server_mode = 1'b1;
      tmo_limit = 32'd0;
      release_init();
      for (int k = 0; k < 12; k++) begin
        if (irq || arp_req_valid) seen++;
        step();
      end
      chk("R12 server quiet", MW'(seen), 0);
      soft_rst = 1'b1; step();
      chk("R10 abort idle", MW'({arp_rep_valid, busy}), 1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule